// File: doc/BRIEF.md
# I2C Target Receiver

This block is the receive half of an I2C target. It samples the shared SCL and SDA lines through a configurable synchroniser. It recognises START, repeated START and STOP conditions and compares the first byte of every transfer with a programmable own address. The own address can be 7 bits wide or 10 bits wide, and the block can also answer the general-call address when that option is enabled. When a master addresses the block for a write, each byte it sends is acknowledged and placed in a receive buffer, and a full flag is raised.

Software, or a small controller next to the block, watches the flags. It takes each byte with a read strobe. It can ask for the next byte to be refused, which ends the session and frees the bus. It can also clear the flag that records a STOP. If a byte is complete while the buffer still holds an unread one, the block holds SCL low until the buffer is read. A STOP or a repeated START always ends the current session, and the block returns to waiting for its address. Both bus lines are open drain, so the block only ever reports when it wants to pull a line low.

Top module: `i2c_target_rx`

## Requirements
- R1: With `ten_bit_mode` low, a first byte whose upper seven bits equal `own_addr[6:0]` and whose bit 0 (R/W) is 0 is acknowledged. With `ten_bit_mode` high, the first byte must be `11110`, then `own_addr[9:8]`, then R/W = 0, and the second byte must equal `own_addr[7:0]`. Each of these two bytes is acknowledged separately.
- R2: The first byte 0x00 is acknowledged only while `gcall_en` is high, and it then sets `gcall_hit`. With `gcall_en` low it is not acknowledged.
- R3: A matching write address clears `master_read`. A matching address with R/W = 1 sets `master_read` and is not acknowledged, because transmit is not provided.
- R4: Every data byte accepted in an addressed write session is copied to `rx_byte` and sets `rx_full`. SDA is pulled low during the ninth clock of that byte.
- R5: A one-cycle pulse on `rd_strobe` clears `rx_full`.
- R6: A pulse on `nack_req` makes the next data byte go unacknowledged. That byte is not loaded into the buffer, and later bytes are ignored until the next START.
- R7: A STOP on the bus sets `stop_seen` and releases both lines. `stop_seen` stays set until `stop_clr` is pulsed.
- R8: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a repeated START the next byte is treated as an address, and a repeated START does not set `stop_seen`.
- R9: A first byte that matches no enabled address is not acknowledged. No byte is loaded until the next START.
- R10: If a byte completes while `rx_full` is high, `scl_drive_low` holds SCL low until `rd_strobe`. The held byte is then loaded and acknowledged.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_drive_low | output | 1 | Pull SCL low (clock hold) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| own_addr | input | 10 | Own target address; only bits 6:0 are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects a 10-bit own address |
| gcall_en | input | 1 | 1 makes the block answer address 0x00 |
| nack_req | input | 1 | Pulse: refuse the next data byte |
| rd_strobe | input | 1 | Pulse: buffer has been read, clear the full flag |
| stop_clr | input | 1 | Pulse: clear the STOP flag |
| rx_byte | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| stop_seen | output | 1 | A STOP has been detected |
| master_read | output | 1 | Last matched address asked for a read |
| gcall_hit | output | 1 | Current session was opened by a general call |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3, one stage deeper than the default. The bit half-period of the modelled master is 12 clocks. Together these show that condition detection and the acknowledge timing survive a longer input delay. They also give the clock-hold test a wide window, in which the bench can confirm that SCL stays low after the master has released it, and then release it by reading the buffer. With the 10-bit mode enabled on the same build, the two-byte address match and its mismatch cases can be reached.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int OWN_ADDR_W = 10;
  localparam logic [4:0] TEN_BIT_HDR = 5'b11110;
  localparam logic [BYTE_W-1:0] GCALL_CODE = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else begin
        scl_pipe[g] <= scl_pipe[g-1];
        sda_pipe[g] <= sda_pipe[g-1];
      end
    end
  end

  assign scl_q = scl_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tgt_pkg::*;
(
  input  logic [BYTE_W-1:0]     byte_in,
  input  logic [OWN_ADDR_W-1:0] own_addr,
  input  logic                  ten_bit,
  input  logic                  gc_en,
  output logic                  hit7,
  output logic                  hit10_hi,
  output logic                  hit10_lo,
  output logic                  hit_gc
);
  always_comb begin
    hit7     = !ten_bit && (byte_in[7:1] == own_addr[6:0]);
    hit10_hi = ten_bit && (byte_in[7:3] == TEN_BIT_HDR)
                       && (byte_in[2:1] == own_addr[9:8]);
    hit10_lo = (byte_in == own_addr[7:0]);
    hit_gc   = gc_en && (byte_in == GCALL_CODE);
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_q,
  input  logic              hit7,
  input  logic              hit10_hi,
  input  logic              hit10_lo,
  input  logic              hit_gc,
  input  logic              rd_strobe,
  input  logic              nack_req,
  input  logic              stop_clr,
  output logic [BYTE_W-1:0] shift_q,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              stop_seen,
  output logic              master_read,
  output logic              gcall_hit,
  output logic              sda_drive_low,
  output logic              scl_drive_low,
  output logic              load_ev
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  tgt_state_t       state;
  logic [CNT_W-1:0] bit_cnt;
  logic             ack_phase;
  logic             pend;
  logic             nack_pend;
  logic             byte_end;

  always_comb begin
    byte_end = scl_fall && (bit_cnt == LAST_BIT) && !ack_phase
               && (state != ST_IDLE);
    load_ev  = (state == ST_DATA)
               && ((byte_end && !nack_pend) || pend)
               && (!rx_full || rd_strobe)
               && !start_ev && !stop_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      ack_phase     <= 1'b0;
      pend          <= 1'b0;
      nack_pend     <= 1'b0;
      shift_q       <= '0;
      rx_byte       <= '0;
      rx_full       <= 1'b0;
      stop_seen     <= 1'b0;
      master_read   <= 1'b0;
      gcall_hit     <= 1'b0;
      sda_drive_low <= 1'b0;
      scl_drive_low <= 1'b0;
    end else begin
      if (rd_strobe) rx_full <= 1'b0;
      if (load_ev) begin
        rx_full <= 1'b1;
        rx_byte <= shift_q;
      end
      if (stop_clr) stop_seen <= 1'b0;
      if (stop_ev)  stop_seen <= 1'b1;
      if (nack_req) nack_pend <= 1'b1;

      if (start_ev || stop_ev) begin
        state         <= start_ev ? ST_ADDR1 : ST_IDLE;
        bit_cnt       <= '0;
        ack_phase     <= 1'b0;
        pend          <= 1'b0;
        gcall_hit     <= 1'b0;
        sda_drive_low <= 1'b0;
        scl_drive_low <= 1'b0;
        if (stop_ev) nack_pend <= 1'b0;
      end else begin
        if (load_ev) begin
          sda_drive_low <= 1'b1;
          scl_drive_low <= 1'b0;
          pend          <= 1'b0;
          ack_phase     <= 1'b1;
        end

        if (scl_rise && (bit_cnt < LAST_BIT) && (state != ST_IDLE)) begin
          shift_q <= {shift_q[BYTE_W-2:0], sda_q};
          bit_cnt <= bit_cnt + 1'b1;
        end

        if (byte_end) begin
          ack_phase <= 1'b1;
          case (state)
            ST_ADDR1: begin
              if (hit_gc) begin
                master_read   <= 1'b0;
                gcall_hit     <= 1'b1;
                sda_drive_low <= 1'b1;
                state         <= ST_DATA;
              end else if ((hit7 || hit10_hi) && !shift_q[0]) begin
                master_read   <= 1'b0;
                sda_drive_low <= 1'b1;
                state         <= hit10_hi ? ST_ADDR2 : ST_DATA;
              end else if (hit7 || hit10_hi) begin
                master_read <= 1'b1;
                state       <= ST_SKIP;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR2: begin
              if (hit10_lo) begin
                sda_drive_low <= 1'b1;
                state         <= ST_DATA;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_DATA: begin
              if (nack_pend) begin
                nack_pend <= 1'b0;
                state     <= ST_SKIP;
              end else if (!load_ev) begin
                pend          <= 1'b1;
                scl_drive_low <= 1'b1;
              end
            end
            default: ;
          endcase
        end

        if (ack_phase && scl_fall) begin
          ack_phase     <= 1'b0;
          sda_drive_low <= 1'b0;
          bit_cnt       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_drive_low,
  output logic                  sda_drive_low,
  input  logic [OWN_ADDR_W-1:0] own_addr,
  input  logic                  ten_bit_mode,
  input  logic                  gcall_en,
  input  logic                  nack_req,
  input  logic                  rd_strobe,
  input  logic                  stop_clr,
  output logic [BYTE_W-1:0]     rx_byte,
  output logic                  rx_full,
  output logic                  stop_seen,
  output logic                  master_read,
  output logic                  gcall_hit
);
  logic              sda_q, start_ev, stop_ev, scl_rise, scl_fall;
  logic              hit7, hit10_hi, hit10_lo, hit_gc, load_ev;
  logic [BYTE_W-1:0] shift_q;

  i2c_tgt_bus_cond #(.STAGES(SYNC_STAGES)) cond_i (
    .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
    .sda_q(sda_q), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_tgt_addr_match match_i (
    .byte_in(shift_q), .own_addr(own_addr), .ten_bit(ten_bit_mode),
    .gc_en(gcall_en), .hit7(hit7), .hit10_hi(hit10_hi),
    .hit10_lo(hit10_lo), .hit_gc(hit_gc)
  );

  i2c_tgt_engine engine_i (
    .clk(clk), .rst(rst), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_q(sda_q),
    .hit7(hit7), .hit10_hi(hit10_hi), .hit10_lo(hit10_lo), .hit_gc(hit_gc),
    .rd_strobe(rd_strobe), .nack_req(nack_req), .stop_clr(stop_clr),
    .shift_q(shift_q), .rx_byte(rx_byte), .rx_full(rx_full),
    .stop_seen(stop_seen), .master_read(master_read), .gcall_hit(gcall_hit),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .load_ev(load_ev)
  );
endmodule

// File: rtl/i2c_target_rx_chk.sv
module i2c_target_rx_chk (
  input logic clk,
  input logic rst,
  input logic rx_full,
  input logic rd_strobe,
  input logic load_ev,
  input logic start_ev,
  input logic stop_ev,
  input logic stop_seen,
  input logic sda_drive_low,
  input logic scl_drive_low
);
  AST_LOAD_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> sda_drive_low); // R4

  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !load_ev) |=> !rx_full); // R5

  AST_STOP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (stop_seen && !sda_drive_low && !scl_drive_low)); // R7

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (!sda_drive_low && !scl_drive_low)); // R8

  AST_HOLD_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    scl_drive_low |-> rx_full); // R10
endmodule

bind i2c_target_rx i2c_target_rx_chk chk_i (
  .clk(clk), .rst(rst), .rx_full(rx_full), .rd_strobe(rd_strobe),
  .load_ev(load_ev), .start_ev(start_ev), .stop_ev(stop_ev),
  .stop_seen(stop_seen), .sda_drive_low(sda_drive_low),
  .scl_drive_low(scl_drive_low)
);

// File: tb/i2c_target_rx_tb_top.sv
`timescale 1ns/1ps
module i2c_target_rx_tb_top;
  localparam int H  = 12;
  localparam int NV = 5;
  // addr[18:11] data[10:3] addr_ack[2] data_ack[1] master_read[0]
  localparam logic [18:0] VEC [NV] = '{
    {8'h74, 8'h5C, 3'b110},
    {8'h76, 8'h11, 3'b000},
    {8'h00, 8'hA5, 3'b110},
    {8'h75, 8'h00, 3'b001},
    {8'h74, 8'hFF, 3'b110}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_drive_low, sda_drive_low;
  logic [9:0] own_addr = 10'h03A;
  logic ten_bit_mode = 1'b0, gcall_en = 1'b1;
  logic nack_req = 1'b0, rd_strobe = 1'b0, stop_clr = 1'b0;
  logic [7:0] rx_byte;
  logic rx_full, stop_seen, master_read, gcall_hit;
  logic bus_scl, bus_sda;
  int total = 0, bad = 0;
  bit done = 1'b0;

  assign bus_scl = scl_m & ~scl_drive_low;
  assign bus_sda = sda_m & ~sda_drive_low;

  always #2 clk = ~clk;

  i2c_target_rx #(.SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst(rst), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .gcall_en(gcall_en),
    .nack_req(nack_req), .rd_strobe(rd_strobe), .stop_clr(stop_clr),
    .rx_byte(rx_byte), .rx_full(rx_full), .stop_seen(stop_seen),
    .master_read(master_read), .gcall_hit(gcall_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw();
    sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw();
    sda_m = 1'b1; hw(); hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0; hw();
    end
    sda_m = 1'b1; hw(); scl_m = 1'b1;
    while (!bus_scl) @(negedge clk);
    hw();
    acked = !bus_sda;
    scl_m = 1'b0; hw();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic ack;
    logic saw_hold;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset values
    check("R11 rx_full", rx_full, 0);
    check("R11 stop_seen", stop_seen, 0);
    check("R11 drives", {scl_drive_low, sda_drive_low}, 0);
    check("R11 rx_byte", rx_byte, 0);
    check("R11 flags", {master_read, gcall_hit}, 0);

    // Vector table: 7-bit own address 0x3A, general call on
    for (int v = 0; v < NV; v++) begin
      bus_start();
      send_byte(VEC[v][18:11], ack);
      check("R1/R3/R9 addr ack", ack, VEC[v][2]);
      check("R3 master_read", master_read, VEC[v][0]);
      check("R2 gcall_hit", gcall_hit, (VEC[v][18:11] == 8'h00));
      send_byte(VEC[v][10:3], ack);
      check("R4/R9 data ack", ack, VEC[v][1]);
      check("R4/R9 rx_full", rx_full, VEC[v][1]);
      if (VEC[v][1]) begin
        check("R4 rx_byte", rx_byte, VEC[v][10:3]);
        pulse(rd_strobe);
        check("R5 read clears", rx_full, 0);
      end
      bus_stop();
      check("R7 stop_seen", stop_seen, 1);
      check("R7 released", {scl_drive_low, sda_drive_low}, 0);
      pulse(stop_clr);
      check("R7 stop_clr", stop_seen, 0);
    end

    // R2 general call refused when disabled
    gcall_en = 1'b0;
    bus_start();
    send_byte(8'h00, ack);
    check("R2 gc disabled", ack, 0);
    bus_stop();
    gcall_en = 1'b1;

    // R1 10-bit address 0x2C5
    ten_bit_mode = 1'b1;
    own_addr = 10'h2C5;
    bus_start();
    send_byte(8'hF4, ack);
    check("R1 ten-bit first", ack, 1);
    send_byte(8'hC5, ack);
    check("R1 ten-bit second", ack, 1);
    send_byte(8'h3C, ack);
    check("R1 ten-bit data ack", ack, 1);
    check("R1 ten-bit data", rx_byte, 8'h3C);
    pulse(rd_strobe);
    bus_stop();
    bus_start();
    send_byte(8'hF4, ack);
    send_byte(8'hC6, ack);
    check("R1 ten-bit low mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'h8A, ack);
    check("R1 seven-bit form in ten-bit mode", ack, 0);
    bus_stop();
    ten_bit_mode = 1'b0;
    own_addr = 10'h03A;

    // R6 software NACK
    bus_start();
    send_byte(8'h74, ack);
    send_byte(8'h21, ack);
    check("R6 first byte ack", ack, 1);
    pulse(rd_strobe);
    pulse(nack_req);
    send_byte(8'h77, ack);
    check("R6 nacked byte", ack, 0);
    check("R6 not loaded flag", rx_full, 0);
    check("R6 not loaded data", rx_byte, 8'h21);
    send_byte(8'h12, ack);
    check("R6 session ended", ack, 0);
    bus_stop();
    pulse(stop_clr);

    // R10 clock hold while buffer full
    bus_start();
    send_byte(8'h74, ack);
    send_byte(8'h01, ack);
    check("R10 first byte", rx_byte, 8'h01);
    saw_hold = 1'b0;
    fork
      send_byte(8'h02, ack);
      begin
        for (int k = 0; k < 2000 && !scl_drive_low; k++) @(negedge clk);
        saw_hold = scl_drive_low;
        repeat (4 * H) @(negedge clk);
        check("R10 scl held", bus_scl, 0);
        check("R10 old byte kept", rx_byte, 8'h01);
        pulse(rd_strobe);
      end
    join
    check("R10 hold seen", saw_hold, 1);
    check("R10 ack after read", ack, 1);
    check("R10 new byte", rx_byte, 8'h02);
    check("R10 full again", rx_full, 1);
    pulse(rd_strobe);

    // R8 repeated START returns to address monitoring
    bus_start();
    send_byte(8'h20, ack);
    check("R8 address after restart", ack, 0);
    send_byte(8'h99, ack);
    check("R8 data ignored", ack, 0);
    check("R8 no load", rx_full, 0);
    check("R8 no stop flag", stop_seen, 0);
    bus_start();
    send_byte(8'h74, ack);
    check("R8 readdressed", ack, 1);
    bus_stop();
    check("R7 final stop", stop_seen, 1);

    finish_run();
  end
endmodule